// File: doc/BRIEF.md
# Baseband Clock Generator

This block derives every baseband timing signal from one 26 MHz reference. It forwards the reference to the controller unchanged. It also produces the following signals:

- a 13 MHz clock for the radio interface logic;
- a subscriber card clock that runs at 3.25 MHz or 1.625 MHz, or is parked low;
- a bit clock with an average of exactly 512 kHz, for the codec and the accessory data bus;
- an 8 kHz frame sync aligned to that bit clock;
- a slow sleep clock of about 135.4 kHz;
- an enable line for the separate DSP crystal oscillator.

All generated clocks are registered levels in the reference domain. A fractional phase accumulator makes the bit clock, so its average rate is exact while single periods differ by one reference cycle.

Static control inputs set the card clock rate, the card clock stop and the idle mode. Idle mode parks every generated clock low and leaves only the forwarded reference running. Every rate change and every stop takes effect at the end of a complete low phase. A clock that is stopped and then released starts with a rising edge. Because of this, no output ever produces a shortened pulse.

Top module: `bb_clkgen`

## Requirements
- R1: While `rst` is high, `rf_clk_o`, `card_clk_o`, `sleep_clk_o`, `bit_clk_o`, `frame_sync_o` and `dsp_osc_en_o` are all 0.
- R2: When `idle_mode` is 0, `rf_clk_o` toggles on every reference cycle, giving a period of 2 reference cycles.
- R3: When running, `card_clk_o` has a period of 8 reference cycles (4 high, 4 low) when `card_slow` is 0, and a period of 16 cycles (8 high, 8 low) when `card_slow` is 1.
- R4: While `card_stop` is 1, `card_clk_o` settles low within 16 reference cycles and stays low. Once `card_stop` returns to 0, the clock runs again at the selected rate.
- R5: `sleep_clk_o` has a period of 192 reference cycles, with 96 cycles high.
- R6: While running, `bit_clk_o` has exactly 32 rising edges in any 1625 consecutive reference cycles. Each of its high phases lasts 25 or 26 cycles.
- R7: `frame_sync_o` rises only in the same cycle as a rising edge of `bit_clk_o`. It rises once every 64 bit-clock rising edges and falls at the next bit-clock rising edge.
- R8: While `idle_mode` is 1, every generated clock and the frame sync settle low within 250 reference cycles and stay low. `ref_clk_o` keeps following the reference. When idle ends, all clocks resume at their rates.
- R9: `dsp_osc_en_o` equals `dsp_osc_req` AND NOT `idle_mode`, as sampled at the previous reference edge.
- R10: No runt pulses appear. Every high phase of `card_clk_o` lasts 4 or 8 cycles and every low phase lasts at least 4 cycles. Every low phase of `bit_clk_o` lasts at least 25 cycles. These limits hold under any sequence of rate, stop and idle changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 26 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_mode | input | 1 | 1 parks all generated clocks low |
| card_slow | input | 1 | Card clock rate: 0 = reference/8, 1 = reference/16 |
| card_stop | input | 1 | 1 parks the card clock low |
| dsp_osc_req | input | 1 | Request to run the DSP oscillator |
| ref_clk_o | output | 1 | Forwarded reference for the controller |
| rf_clk_o | output | 1 | Reference/2 clock for the radio interface |
| card_clk_o | output | 1 | Subscriber card clock |
| sleep_clk_o | output | 1 | Reference/192 sleep clock |
| bit_clk_o | output | 1 | 512 kHz average bit clock |
| frame_sync_o | output | 1 | 8 kHz frame sync, high for one bit period |
| dsp_osc_en_o | output | 1 | DSP oscillator enable |

## Verification
A wrong divider count or a wrong latched rate select shows up in the next phase of the card or sleep clock, as a period or high time that is off by cycles. A rate change applied in mid-phase shows up within one card period as a high phase outside 4 or 8 cycles. An accumulator with the wrong step or modulus makes the count of bit-clock edges in a 1625-cycle window differ from 32. A frame counter that is off by one moves the sync away from a spacing of 64 edges within two frames, about 6500 reference cycles. A gating fault appears as a clock still toggling 250 cycles into idle, or as a shortened low phase right after an idle period or a stop.

// File: rtl/bbclk_pkg.sv
package bbclk_pkg;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // bits needed to hold values 0 .. n-1 (at least one bit)
  function automatic int unsigned cw_of(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/bbclk_div.sv
// Gated integer divider with two selectable half periods.
// Rate is latched and stop is honoured only at the end of a low phase.
module bbclk_div
  import bbclk_pkg::*;
#(
  parameter int unsigned HALF_A = 4,
  parameter int unsigned HALF_B = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic sel_b_i,
  output logic clk_o
);

  localparam int unsigned HMAX = max2(HALF_A, HALF_B);
  localparam int unsigned CW   = cw_of(HMAX);
  localparam logic [CW-1:0] LAST_A = CW'(HALF_A - 1);
  localparam logic [CW-1:0] LAST_B = CW'(HALF_B - 1);

  logic [CW-1:0] cnt;
  logic          sel_q;
  logic          running;
  logic          out_q;
  logic [CW-1:0] last;
  logic          phase_end;

  assign last      = sel_q ? LAST_B : LAST_A;
  assign phase_end = (cnt == last);
  assign clk_o     = out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      sel_q   <= 1'b0;
      running <= 1'b0;
      out_q   <= 1'b0;
    end else if (!running) begin
      cnt   <= '0;
      out_q <= 1'b0;
      if (run_i) begin
        running <= 1'b1;
        sel_q   <= sel_b_i;
        out_q   <= 1'b1;
      end
    end else if (phase_end) begin
      cnt <= '0;
      if (out_q) begin
        out_q <= 1'b0;
      end else if (run_i) begin
        sel_q <= sel_b_i;
        out_q <= 1'b1;
      end else begin
        running <= 1'b0;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R10: the divider only parks after a low phase
  p_stop_from_low_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> (!clk_o && !$past(clk_o)));

  // R10: the latched rate never changes inside a high phase
  p_rate_hold_high_r10: assert property (@(posedge clk) disable iff (rst)
    (clk_o && $past(clk_o)) |-> $stable(sel_q));

endmodule

// File: rtl/bbclk_nco.sv
// Fractional bit clock: each accumulator wrap toggles the output.
module bbclk_nco
  import bbclk_pkg::*;
#(
  parameter int unsigned NUM = 32,
  parameter int unsigned DEN = 1625
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic clk_o,
  output logic rise_o,
  output logic halt_o
);

  localparam int unsigned STEP = 2 * NUM;
  localparam int unsigned AW   = cw_of(DEN);

  logic [AW-1:0] acc;
  logic [AW:0]   sum;
  logic          wrap;
  logic          out_q;
  logic          halt_q;

  assign sum    = {1'b0, acc} + (AW+1)'(STEP);
  assign wrap   = (sum >= (AW+1)'(DEN));
  assign rise_o = !halt_q && wrap && !out_q && run_i;
  assign clk_o  = out_q;
  assign halt_o = halt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      out_q  <= 1'b0;
      halt_q <= 1'b1;
    end else if (halt_q) begin
      acc   <= '0;
      out_q <= 1'b0;
      if (run_i) halt_q <= 1'b0;
    end else if (wrap) begin
      acc <= AW'(sum - (AW+1)'(DEN));
      if (out_q) begin
        out_q <= 1'b0;
      end else if (run_i) begin
        out_q <= 1'b1;
      end else begin
        halt_q <= 1'b1;
        acc    <= '0;
      end
    end else begin
      acc <= sum[AW-1:0];
    end
  end

  // R6: accumulator stays inside its modulus
  p_acc_bound_r6: assert property (@(posedge clk) disable iff (rst)
    acc < AW'(DEN));

  // R8: the clock is never high while parked
  p_no_high_halted_r8: assert property (@(posedge clk) disable iff (rst)
    clk_o |-> !halt_o);

endmodule

// File: rtl/bbclk_frame.sv
// Frame sync: one pulse per BITS rising bit-clock edges, one bit long.
module bbclk_frame
  import bbclk_pkg::*;
#(
  parameter int unsigned BITS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic halt_i,
  output logic fs_o
);

  localparam int unsigned CW = cw_of(BITS);
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [CW-1:0] cnt;
  logic          fs_q;

  assign fs_o = fs_q;

  always_ff @(posedge clk) begin
    if (rst || halt_i) begin
      cnt  <= '0;
      fs_q <= 1'b0;
    end else if (rise_i) begin
      fs_q <= (cnt == '0);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  // R7: the sync only rises with a bit-clock rising edge
  p_sync_align_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(fs_q) |-> $past(rise_i));

  // R8: a parked bit clock clears the sync
  p_halt_clear_r8: assert property (@(posedge clk) disable iff (rst)
    halt_i |=> !fs_q);

endmodule

// File: rtl/bb_clkgen.sv
module bb_clkgen
  import bbclk_pkg::*;
#(
  parameter int unsigned RF_HALF    = 1,
  parameter int unsigned CARD_FAST  = 4,
  parameter int unsigned CARD_SLOW  = 8,
  parameter int unsigned SLEEP_HALF = 96,
  parameter int unsigned BIT_NUM    = 32,
  parameter int unsigned BIT_DEN    = 1625,
  parameter int unsigned FRAME_BITS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic idle_mode,
  input  logic card_slow,
  input  logic card_stop,
  input  logic dsp_osc_req,
  output logic ref_clk_o,
  output logic rf_clk_o,
  output logic card_clk_o,
  output logic sleep_clk_o,
  output logic bit_clk_o,
  output logic frame_sync_o,
  output logic dsp_osc_en_o
);

  logic run_all;
  logic run_card;
  logic bit_rise;
  logic bit_halt;
  logic dsp_en_q;

  assign run_all   = !idle_mode;
  assign run_card  = !idle_mode && !card_stop;
  assign ref_clk_o = clk;

  bbclk_div #(.HALF_A(RF_HALF), .HALF_B(RF_HALF)) u_rf (
    .clk(clk), .rst(rst), .run_i(run_all), .sel_b_i(1'b0), .clk_o(rf_clk_o)
  );

  bbclk_div #(.HALF_A(CARD_FAST), .HALF_B(CARD_SLOW)) u_card (
    .clk(clk), .rst(rst), .run_i(run_card), .sel_b_i(card_slow), .clk_o(card_clk_o)
  );

  bbclk_div #(.HALF_A(SLEEP_HALF), .HALF_B(SLEEP_HALF)) u_sleep (
    .clk(clk), .rst(rst), .run_i(run_all), .sel_b_i(1'b0), .clk_o(sleep_clk_o)
  );

  bbclk_nco #(.NUM(BIT_NUM), .DEN(BIT_DEN)) u_bit (
    .clk(clk), .rst(rst), .run_i(run_all),
    .clk_o(bit_clk_o), .rise_o(bit_rise), .halt_o(bit_halt)
  );

  bbclk_frame #(.BITS(FRAME_BITS)) u_frame (
    .clk(clk), .rst(rst), .rise_i(bit_rise), .halt_i(bit_halt), .fs_o(frame_sync_o)
  );

  always_ff @(posedge clk) begin
    if (rst) dsp_en_q <= 1'b0;
    else     dsp_en_q <= dsp_osc_req && !idle_mode;
  end
  assign dsp_osc_en_o = dsp_en_q;

  // R9: idle always drops the oscillator enable
  p_dsp_idle_r9: assert property (@(posedge clk) disable iff (rst)
    idle_mode |=> !dsp_osc_en_o);

  // R4: a stopped card clock that is low stays low
  p_card_stop_r4: assert property (@(posedge clk) disable iff (rst)
    (card_stop && !card_clk_o) |=> !card_clk_o);

endmodule

// File: tb/bb_clkgen_bench.sv
module bb_clkgen_bench;

  logic clk = 1'b0;
  always #2ns clk = ~clk;

  logic rst = 1'b1;
  logic idle_mode = 1'b0;
  logic card_slow = 1'b0;
  logic card_stop = 1'b0;
  logic dsp_osc_req = 1'b0;
  logic ref_clk_o, rf_clk_o, card_clk_o, sleep_clk_o, bit_clk_o, frame_sync_o, dsp_osc_en_o;

  bb_clkgen u_bb_clkgen (
    .clk(clk), .rst(rst), .idle_mode(idle_mode), .card_slow(card_slow),
    .card_stop(card_stop), .dsp_osc_req(dsp_osc_req), .ref_clk_o(ref_clk_o),
    .rf_clk_o(rf_clk_o), .card_clk_o(card_clk_o), .sleep_clk_o(sleep_clk_o),
    .bit_clk_o(bit_clk_o), .frame_sync_o(frame_sync_o), .dsp_osc_en_o(dsp_osc_en_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_card_per(input bit slow);
    return slow ? 16 : 8;
  endfunction

  function automatic int exp_rises(input int cycles);
    return (cycles * 32) / 1625;
  endfunction

  function automatic bit exp_dsp(input bit req, input bit idle);
    return req && !idle;
  endfunction

  // monitor state
  logic card_prev = 0, rf_prev = 0, sl_prev = 0, bit_prev = 0, fs_prev = 0;
  int card_run = 0, card_since = 0, card_per = 0;
  int rf_since = 0, rf_per = 0;
  int sl_run = 0, sl_since = 0, sl_per = 0, sl_hi = 0;
  int bit_run = 0, bit_rises = 0;
  int fs_gap = 0, fs_rises = 0;
  bit fs_seen = 0;

  always @(negedge clk) begin
    bit brose;
    // card clock
    if (card_clk_o != card_prev) begin
      if (mon_en) begin
        if (card_prev) chk(card_run == 4 || card_run == 8, "R10 card high phase", card_run, 4);
        else           chk(card_run >= 4, "R10 card low phase", card_run, 4);
      end
      card_run = 1;
      if (card_clk_o) begin card_per = card_since; card_since = 0; end
    end else card_run++;
    card_since++;
    // rf clock
    if (rf_clk_o && !rf_prev) begin rf_per = rf_since; rf_since = 0; end
    rf_since++;
    // sleep clock
    if (sleep_clk_o != sl_prev) begin
      if (sl_prev) sl_hi = sl_run;
      sl_run = 1;
      if (sleep_clk_o) begin sl_per = sl_since; sl_since = 0; end
    end else sl_run++;
    sl_since++;
    // bit clock and frame sync
    brose = bit_clk_o && !bit_prev;
    if (bit_clk_o != bit_prev) begin
      if (mon_en) begin
        if (bit_prev) chk(bit_run == 25 || bit_run == 26, "R6 bit high phase", bit_run, 25);
        else          chk(bit_run >= 25, "R10 bit low phase", bit_run, 25);
      end
      bit_run = 1;
    end else bit_run++;
    if (brose) begin
      bit_rises++;
      fs_gap++;
      if (mon_en && fs_prev) chk(!frame_sync_o, "R7 sync width", frame_sync_o, 0);
    end
    if (frame_sync_o && !fs_prev) begin
      if (mon_en) begin
        chk(brose, "R7 sync aligned to bit rise", brose, 1);
        if (fs_seen) chk(fs_gap == 64, "R7 sync spacing", fs_gap, 64);
      end
      fs_rises++;
      fs_gap = 0;
      fs_seen = 1;
    end
    if (idle_mode) fs_seen = 0;
    card_prev = card_clk_o; rf_prev = rf_clk_o; sl_prev = sleep_clk_o;
    bit_prev = bit_clk_o; fs_prev = frame_sync_o;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_running(input string tag, input bit slow);
    chk(rf_per == 2, {tag, " rf period"}, rf_per, 2);
    chk(card_per == exp_card_per(slow), {tag, " card period"}, card_per, exp_card_per(slow));
    chk(sl_per == 192, {tag, " sleep period"}, sl_per, 192);
  endtask

  initial begin
    #(600000ns);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int c0;
    int highs;
    seed = $urandom(32'h5EED_0A11);
    wait_cyc(6);
    // R1: reset state
    chk(rf_clk_o == 0, "R1 rf in reset", rf_clk_o, 0);
    chk(card_clk_o == 0, "R1 card in reset", card_clk_o, 0);
    chk(sleep_clk_o == 0, "R1 sleep in reset", sleep_clk_o, 0);
    chk(bit_clk_o == 0, "R1 bit in reset", bit_clk_o, 0);
    chk(frame_sync_o == 0, "R1 sync in reset", frame_sync_o, 0);
    chk(dsp_osc_en_o == 0, "R1 dsp enable in reset", dsp_osc_en_o, 0);

    rst = 1'b0;
    mon_en = 1'b1;
    dsp_osc_req = 1'b1;
    wait_cyc(1);
    chk(dsp_osc_en_o == exp_dsp(1, 0), "R9 dsp enable follows request", dsp_osc_en_o, 1);

    wait_cyc(400);
    chk(rf_per == 2, "R2 rf period", rf_per, 2);
    chk(card_per == exp_card_per(0), "R3 card fast period", card_per, 8);
    chk(sl_per == 192, "R5 sleep period", sl_per, 192);
    chk(sl_hi == 96, "R5 sleep high time", sl_hi, 96);

    c0 = bit_rises;
    wait_cyc(1625);
    chk(bit_rises - c0 == exp_rises(1625), "R6 bit rises per window", bit_rises - c0, 32);
    c0 = bit_rises;
    wait_cyc(3250);
    chk(bit_rises - c0 == exp_rises(3250), "R6 bit rises double window", bit_rises - c0, 64);

    wait_cyc(4000);
    chk(fs_rises >= 2, "R7 sync pulses seen", fs_rises, 2);

    card_slow = 1'b1;
    wait_cyc(200);
    chk(card_per == exp_card_per(1), "R3 card slow period", card_per, 16);

    card_stop = 1'b1;
    wait_cyc(20);
    highs = 0;
    for (int i = 0; i < 100; i++) begin
      wait_cyc(1);
      if (card_clk_o) highs++;
    end
    chk(highs == 0, "R4 card parked low", highs, 0);
    chk(rf_per == 2, "R4 other clocks unaffected by card stop", rf_per, 2);
    card_stop = 1'b0;
    wait_cyc(60);
    chk(card_per == 16, "R4 card resumes", card_per, 16);

    dsp_osc_req = 1'b0;
    wait_cyc(1);
    chk(dsp_osc_en_o == exp_dsp(0, 0), "R9 dsp enable drops", dsp_osc_en_o, 0);

    // idle
    idle_mode = 1'b1;
    dsp_osc_req = 1'b1;
    wait_cyc(250);
    highs = 0;
    for (int i = 0; i < 300; i++) begin
      wait_cyc(1);
      if (rf_clk_o || card_clk_o || sleep_clk_o || bit_clk_o || frame_sync_o) highs++;
    end
    chk(highs == 0, "R8 generated clocks parked in idle", highs, 0);
    chk(dsp_osc_en_o == exp_dsp(1, 1), "R9 dsp enable held low in idle", dsp_osc_en_o, 0);
    chk(ref_clk_o == 1'b0, "R8 reference low phase", ref_clk_o, 0);
    @(posedge clk);
    #1ns;
    chk(ref_clk_o == 1'b1, "R8 reference high phase", ref_clk_o, 1);
    idle_mode = 1'b0;
    wait_cyc(600);
    check_running("R8 after idle", 1'b1);

    // random phase with directed boundaries mixed in
    for (int k = 0; k < 60; k++) begin
      int hold;
      bit r_req, r_idle;
      card_slow = 1'($urandom % 2);
      card_stop = ($urandom % 4) == 0;
      r_idle = ($urandom % 6) == 0;
      r_req = 1'($urandom % 2);
      idle_mode = r_idle;
      dsp_osc_req = r_req;
      hold = (k % 10 == 0) ? 1 : int'($urandom % 300) + 1;
      wait_cyc(1);
      chk(dsp_osc_en_o == exp_dsp(r_req, r_idle), "R9 dsp enable random", dsp_osc_en_o,
          exp_dsp(r_req, r_idle));
      if (hold > 1) wait_cyc(hold - 1);
    end

    idle_mode = 1'b0;
    card_stop = 1'b0;
    card_slow = 1'b0;
    wait_cyc(800);
    check_running("R3 final", 1'b0);
    c0 = bit_rises;
    wait_cyc(1625);
    chk(bit_rises - c0 == 32, "R6 bit rises after random", bit_rises - c0, 32);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule